// File: doc/BRIEF.md
# Transmit completion indication writer

This block turns transmit-completion events into 32-bit indication words and queues them for the host. A completion event is raised once the last byte of a packet has been fetched from memory. It does not wait for the packet to leave the line interface. Each event carries an error flag, a virtual-channel number, a flag saying whether the channel's next descriptor is valid, the low bits of the finished descriptor's start address, and a mailbox select. The block packs these fields into one word and appends it to one of the transmit mailboxes. Each mailbox is a small FIFO.

Every mailbox has a bit in a status vector. A parameter selects what the bit means: either "mailbox holds entries", or a sticky flag that the host clears by writing a one. The interrupt output is the registered OR of all status bits that are not masked. The host reads a mailbox by selecting it, looking at the head word and pulsing a pop. It also clears status bits, clears the per-mailbox sticky overflow bits and loads the interrupt mask.

Several event sources may report in the same cycle. Events that target the same mailbox are all placed in that mailbox in one cycle, and the lower-numbered source goes first. If a mailbox is full, the event is dropped and the mailbox's overflow bit is raised.

Top module: `txind_writer`

## Requirements
- R1: A stored word holds, from bit 31 down: bit 31 = 1 when the event reports no error and 0 when it reports an error (input evtError = 1 means an error occurred); bits 30:16 = the 15-bit VC number; bit 15 = 1 when the next descriptor is valid and the VC stays active, and 0 when the VC goes idle; bits 14:0 = the 15 low address bits given on evtDescLo.
- R2: Event i goes to the mailbox given by its evtMbox field (0 selects the first transmit mailbox, 1 the second). rdData shows the oldest entry of the mailbox selected by rdMbox, and rdAvail is 1 when that mailbox holds an entry. A pulse on rdPop while rdAvail is 1 removes that entry at the next edge, so entries come out in arrival order.
- R3: An event whose mailbox already holds DEPTH entries before the clock edge is dropped and leaves the mailbox contents unchanged, even if the host pops in the same cycle. The drop sets that mailbox's overflow bit at the edge. The bit stays set until the host writes a one to ovfClr for that mailbox. If a drop and a clear land in the same cycle, the bit stays set.
- R4: When several events target the same mailbox in one cycle, they are stored in the order of their source number, lowest first. When there is less room than events, the lower-numbered sources fill the room and the others are dropped.
- R5: With STATUS_STICKY = 0, mboxStatus[m] is 1 exactly when mailbox m holds at least one entry, and stClr has no effect.
- R6: With STATUS_STICKY = 1, mboxStatus[m] becomes 1 at the edge where an entry is stored in mailbox m. It returns to 0 only at an edge where stClr[m] is 1 and no entry is stored in that mailbox in the same cycle.
- R7: irq after an edge equals the OR over m of (mboxStatus[m] AND NOT mask[m]) just before that edge, which gives one cycle of latency.
- R8: A cycle with maskWe = 1 loads maskData into the mask at the edge. A mask bit of 1 keeps that mailbox out of the interrupt.
- R9: After reset all mailboxes are empty, and status, overflow, mask and irq are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| evtValid | input | NUM_SRC | Completion event strobe per source |
| evtError | input | NUM_SRC | 1 = the packet ended with an error |
| evtNextValid | input | NUM_SRC | 1 = next descriptor valid, VC stays active |
| evtVc | input | NUM_SRC*15 | VC number per source |
| evtDescLo | input | NUM_SRC*15 | Low 15 bits of the descriptor start address |
| evtMbox | input | NUM_SRC*MB_W | Target mailbox per source |
| rdMbox | input | MB_W | Mailbox the host is reading |
| rdPop | input | 1 | Remove the head of the selected mailbox |
| stClr | input | NUM_MBOX | Write-one-to-clear for status (sticky mode) |
| ovfClr | input | NUM_MBOX | Write-one-to-clear for overflow bits |
| maskWe | input | 1 | Load the interrupt mask |
| maskData | input | NUM_MBOX | New mask value, 1 = masked |
| rdData | output | 32 | Head word of the selected mailbox |
| rdAvail | output | 1 | Selected mailbox is not empty |
| mboxStatus | output | NUM_MBOX | Per-mailbox status bits |
| overflow | output | NUM_MBOX | Sticky drop flags |
| irq | output | 1 | Registered interrupt |

## Verification
The bench builds two copies of the block, each with two sources, two mailboxes and a depth of four. One copy uses the non-empty status meaning and the other uses the sticky write-one-to-clear meaning. Both copies receive the same stimulus, so a single run compares the two status rules and shows that stClr is ignored in the first mode. The shallow depth lets random traffic fill the mailboxes often. It also makes it easy to set up the case where two events arrive in the same cycle with only one free slot.

// File: rtl/txind_pkg.sv
package txind_pkg;
  localparam int VC_W   = 15;
  localparam int DESC_W = 15;
  localparam int SLOT_W = 4;

  // per-source write strobe from control to datapath
  typedef struct packed {
    logic              en;
    logic [SLOT_W-1:0] slot;
  } srcWr_t;

  function automatic logic [31:0] packInd(input logic err, input logic [VC_W-1:0] vc,
                                          input logic nextOk, input logic [DESC_W-1:0] desc);
    return {~err, vc, nextOk, desc};
  endfunction
endpackage

// File: rtl/txind_ctrl.sv
module txind_ctrl
  import txind_pkg::*;
#(
  parameter int NUM_SRC       = 2,
  parameter int NUM_MBOX      = 2,
  parameter int DEPTH         = 4,
  parameter bit STATUS_STICKY = 1'b0,
  localparam int MB_W  = (NUM_MBOX > 1) ? $clog2(NUM_MBOX) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_SRC-1:0]       evtValid,
  input  logic [NUM_SRC*MB_W-1:0]  evtMbox,
  input  logic [CNT_W-1:0]         count [NUM_MBOX],
  input  logic [MB_W-1:0]          rdMbox,
  input  logic                     rdPop,
  input  logic [NUM_MBOX-1:0]      stClr,
  input  logic [NUM_MBOX-1:0]      ovfClr,
  input  logic                     maskWe,
  input  logic [NUM_MBOX-1:0]      maskData,
  output srcWr_t                   wr [NUM_SRC],
  output logic [NUM_MBOX-1:0]      popEn,
  output logic [NUM_MBOX-1:0]      status,
  output logic [NUM_MBOX-1:0]      overflow,
  output logic [NUM_MBOX-1:0]      maskQ,
  output logic                     irq
);
  logic [SLOT_W:0]       taken [NUM_MBOX];
  logic [NUM_MBOX-1:0]   stored;
  logic [NUM_MBOX-1:0]   drop;

  // acceptance: sources in ascending order claim the free slots
  always_comb begin
    for (int m = 0; m < NUM_MBOX; m++) taken[m] = '0;
    stored = '0;
    drop   = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      wr[i] = '0;
      for (int m = 0; m < NUM_MBOX; m++) begin
        if (evtValid[i] && (int'(evtMbox[i*MB_W +: MB_W]) == m)) begin
          if ((int'(count[m]) + int'(taken[m])) < DEPTH) begin
            wr[i].en   = 1'b1;
            wr[i].slot = SLOT_W'(taken[m]);
            taken[m]   = taken[m] + 1'b1;
            stored[m]  = 1'b1;
          end else begin
            drop[m] = 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    for (int m = 0; m < NUM_MBOX; m++)
      popEn[m] = rdPop && (int'(rdMbox) == m) && (count[m] != '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      overflow <= '0;
      maskQ    <= '0;
      irq      <= 1'b0;
    end else begin
      overflow <= (overflow & ~ovfClr) | drop;
      if (maskWe) maskQ <= maskData;
      irq <= |(status & ~maskQ);
    end
  end

  generate
    if (STATUS_STICKY) begin : g_sticky
      logic [NUM_MBOX-1:0] stReg;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stReg <= '0;
        else       stReg <= (stReg & ~stClr) | stored;
      end
      assign status = stReg;
    end else begin : g_level
      logic unusedClr;
      assign unusedClr = ^stClr;
      for (genvar m = 0; m < NUM_MBOX; m++) begin : g_bit
        assign status[m] = (count[m] != '0);
      end
    end
  endgenerate
endmodule

// File: rtl/txind_dpath.sv
module txind_dpath
  import txind_pkg::*;
#(
  parameter int NUM_SRC  = 2,
  parameter int NUM_MBOX = 2,
  parameter int DEPTH    = 4,
  localparam int MB_W  = (NUM_MBOX > 1) ? $clog2(NUM_MBOX) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  srcWr_t                     wr [NUM_SRC],
  input  logic [NUM_MBOX-1:0]        popEn,
  input  logic [NUM_SRC-1:0]         evtError,
  input  logic [NUM_SRC-1:0]         evtNextValid,
  input  logic [NUM_SRC*VC_W-1:0]    evtVc,
  input  logic [NUM_SRC*DESC_W-1:0]  evtDescLo,
  input  logic [NUM_SRC*MB_W-1:0]    evtMbox,
  input  logic [MB_W-1:0]            rdMbox,
  output logic [CNT_W-1:0]           count [NUM_MBOX],
  output logic [31:0]                rdData,
  output logic                       rdAvail
);
  logic [31:0]       mem   [NUM_MBOX][DEPTH];
  logic [PTR_W-1:0]  wrPtr [NUM_MBOX];
  logic [PTR_W-1:0]  rdPtr [NUM_MBOX];
  logic [SLOT_W:0]   addCnt [NUM_MBOX];
  logic [31:0]       word  [NUM_SRC];

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_pack
    assign word[i] = packInd(evtError[i], evtVc[i*VC_W +: VC_W], evtNextValid[i],
                             evtDescLo[i*DESC_W +: DESC_W]);
  end

  always_comb begin
    for (int m = 0; m < NUM_MBOX; m++) begin
      addCnt[m] = '0;
      for (int i = 0; i < NUM_SRC; i++)
        if (wr[i].en && (int'(evtMbox[i*MB_W +: MB_W]) == m)) addCnt[m] = addCnt[m] + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_SRC; i++) begin
      for (int m = 0; m < NUM_MBOX; m++) begin
        if (wr[i].en && (int'(evtMbox[i*MB_W +: MB_W]) == m))
          mem[m][wrPtr[m] + PTR_W'(wr[i].slot)] <= word[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int m = 0; m < NUM_MBOX; m++) begin
        wrPtr[m] <= '0;
        rdPtr[m] <= '0;
        count[m] <= '0;
      end
    end else begin
      for (int m = 0; m < NUM_MBOX; m++) begin
        wrPtr[m] <= wrPtr[m] + PTR_W'(addCnt[m]);
        rdPtr[m] <= rdPtr[m] + PTR_W'(popEn[m]);
        count[m] <= count[m] + CNT_W'(addCnt[m]) - CNT_W'(popEn[m]);
      end
    end
  end

  always_comb begin
    rdAvail = 1'b0;
    rdData  = '0;
    for (int m = 0; m < NUM_MBOX; m++) begin
      if (int'(rdMbox) == m && count[m] != '0) begin
        rdAvail = 1'b1;
        rdData  = mem[m][rdPtr[m]];
      end
    end
  end
endmodule

// File: rtl/txind_writer.sv
module txind_writer
  import txind_pkg::*;
#(
  parameter int NUM_SRC       = 2,
  parameter int NUM_MBOX      = 2,
  parameter int DEPTH         = 4,
  parameter bit STATUS_STICKY = 1'b0,
  localparam int MB_W  = (NUM_MBOX > 1) ? $clog2(NUM_MBOX) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_SRC-1:0]         evtValid,
  input  logic [NUM_SRC-1:0]         evtError,
  input  logic [NUM_SRC-1:0]         evtNextValid,
  input  logic [NUM_SRC*VC_W-1:0]    evtVc,
  input  logic [NUM_SRC*DESC_W-1:0]  evtDescLo,
  input  logic [NUM_SRC*MB_W-1:0]    evtMbox,
  input  logic [MB_W-1:0]            rdMbox,
  input  logic                       rdPop,
  input  logic [NUM_MBOX-1:0]        stClr,
  input  logic [NUM_MBOX-1:0]        ovfClr,
  input  logic                       maskWe,
  input  logic [NUM_MBOX-1:0]        maskData,
  output logic [31:0]                rdData,
  output logic                       rdAvail,
  output logic [NUM_MBOX-1:0]        mboxStatus,
  output logic [NUM_MBOX-1:0]        overflow,
  output logic                       irq
);
  srcWr_t              wr [NUM_SRC];
  logic [NUM_MBOX-1:0] popEn;
  logic [CNT_W-1:0]    count [NUM_MBOX];
  logic [NUM_MBOX-1:0] maskQ;

  txind_ctrl #(.NUM_SRC(NUM_SRC), .NUM_MBOX(NUM_MBOX), .DEPTH(DEPTH),
               .STATUS_STICKY(STATUS_STICKY)) u_ctrl (
    .clk(clk), .rstN(rstN), .evtValid(evtValid), .evtMbox(evtMbox), .count(count),
    .rdMbox(rdMbox), .rdPop(rdPop), .stClr(stClr), .ovfClr(ovfClr),
    .maskWe(maskWe), .maskData(maskData), .wr(wr), .popEn(popEn),
    .status(mboxStatus), .overflow(overflow), .maskQ(maskQ), .irq(irq)
  );

  txind_dpath #(.NUM_SRC(NUM_SRC), .NUM_MBOX(NUM_MBOX), .DEPTH(DEPTH)) u_dpath (
    .clk(clk), .rstN(rstN), .wr(wr), .popEn(popEn), .evtError(evtError),
    .evtNextValid(evtNextValid), .evtVc(evtVc), .evtDescLo(evtDescLo),
    .evtMbox(evtMbox), .rdMbox(rdMbox), .count(count), .rdData(rdData),
    .rdAvail(rdAvail)
  );
endmodule

// File: rtl/txind_writer_chk.sv
module txind_writer_chk #(
  parameter int NUM_MBOX      = 2,
  parameter bit STATUS_STICKY = 1'b0,
  localparam int MB_W = (NUM_MBOX > 1) ? $clog2(NUM_MBOX) : 1
) (
  input logic                clk,
  input logic                rstN,
  input logic [MB_W-1:0]     rdMbox,
  input logic                rdAvail,
  input logic [NUM_MBOX-1:0] mboxStatus,
  input logic [NUM_MBOX-1:0] overflow,
  input logic [NUM_MBOX-1:0] ovfClr,
  input logic [NUM_MBOX-1:0] maskQ,
  input logic                irq
);
  AST_IRQ_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    irq == $past(|(mboxStatus & ~maskQ))); // R7

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    $past(&maskQ) |-> !irq); // R8

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (($past(overflow) & ~$past(ovfClr) & ~overflow) == '0)); // R3

  generate
    if (!STATUS_STICKY) begin : g_lvl
      AST_STATUS_AVAIL: assert property (@(posedge clk) disable iff (!rstN)
        (int'(rdMbox) < NUM_MBOX) |-> (mboxStatus[rdMbox] == rdAvail)); // R5
    end
  endgenerate
endmodule

bind txind_writer txind_writer_chk #(.NUM_MBOX(NUM_MBOX), .STATUS_STICKY(STATUS_STICKY)) u_chk (
  .clk(clk), .rstN(rstN), .rdMbox(rdMbox), .rdAvail(rdAvail), .mboxStatus(mboxStatus),
  .overflow(overflow), .ovfClr(ovfClr), .maskQ(maskQ), .irq(irq)
);

// File: tb/txind_writer_bench.sv
module txind_writer_bench;
  localparam int NS = 2;
  localparam int NM = 2;
  localparam int D  = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic [NS-1:0]    evtValid, evtError, evtNextValid;
  logic [NS*15-1:0] evtVc, evtDescLo;
  logic [NS-1:0]    evtMbox;
  logic             rdMbox, rdPop, maskWe;
  logic [NM-1:0]    stClr, ovfClr, maskData;

  logic [31:0]   rdDataW [2];
  logic          rdAvailW [2];
  logic [NM-1:0] statusW [2];
  logic [NM-1:0] ovfW [2];
  logic          irqW [2];

  txind_writer #(.NUM_SRC(NS), .NUM_MBOX(NM), .DEPTH(D), .STATUS_STICKY(1'b0)) u_txind_writer (
    .clk(clk), .rstN(rstN), .evtValid(evtValid), .evtError(evtError),
    .evtNextValid(evtNextValid), .evtVc(evtVc), .evtDescLo(evtDescLo), .evtMbox(evtMbox),
    .rdMbox(rdMbox), .rdPop(rdPop), .stClr(stClr), .ovfClr(ovfClr), .maskWe(maskWe),
    .maskData(maskData), .rdData(rdDataW[0]), .rdAvail(rdAvailW[0]),
    .mboxStatus(statusW[0]), .overflow(ovfW[0]), .irq(irqW[0]));

  txind_writer #(.NUM_SRC(NS), .NUM_MBOX(NM), .DEPTH(D), .STATUS_STICKY(1'b1)) u_txind_writer_sticky (
    .clk(clk), .rstN(rstN), .evtValid(evtValid), .evtError(evtError),
    .evtNextValid(evtNextValid), .evtVc(evtVc), .evtDescLo(evtDescLo), .evtMbox(evtMbox),
    .rdMbox(rdMbox), .rdPop(rdPop), .stClr(stClr), .ovfClr(ovfClr), .maskWe(maskWe),
    .maskData(maskData), .rdData(rdDataW[1]), .rdAvail(rdAvailW[1]),
    .mboxStatus(statusW[1]), .overflow(ovfW[1]), .irq(irqW[1]));

  int vectors = 0;
  int fails = 0;

  // reference model, index 0 = level status, 1 = sticky status
  logic [31:0]   q [2][NM][$];
  logic [NM-1:0] stE [2];
  logic [NM-1:0] ovfE [2];
  logic [NM-1:0] maskE [2];
  logic          irqE [2];

  function automatic logic [31:0] expWord(logic err, logic [14:0] vc, logic nv, logic [14:0] lo);
    return {~err, vc, nv, lo};  // R1 layout
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic clearIn();
    evtValid = '0; evtError = '0; evtNextValid = '0; evtVc = '0; evtDescLo = '0;
    evtMbox = '0; rdPop = 1'b0; stClr = '0; ovfClr = '0; maskWe = 1'b0; maskData = '0;
  endtask

  task automatic setEvt(int i, logic err, logic [14:0] vc, logic nv, logic [14:0] lo, logic mb);
    evtValid[i] = 1'b1; evtError[i] = err; evtNextValid[i] = nv;
    evtVc[i*15 +: 15] = vc; evtDescLo[i*15 +: 15] = lo; evtMbox[i] = mb;
  endtask

  task automatic modelStep();
    for (int k = 0; k < 2; k++) begin
      logic [NM-1:0] stPre;
      logic [NM-1:0] stored;
      logic [NM-1:0] drop;
      int pre [NM];
      int tk [NM];
      for (int m = 0; m < NM; m++) begin
        stPre[m] = (k == 0) ? (q[k][m].size() != 0) : stE[k][m];
        pre[m] = q[k][m].size();
        tk[m] = 0;
      end
      irqE[k] = |(stPre & ~maskE[k]);
      stored = '0; drop = '0;
      if (rdPop && pre[rdMbox] > 0) void'(q[k][rdMbox].pop_front());
      for (int i = 0; i < NS; i++) begin
        if (evtValid[i]) begin
          int m = int'(evtMbox[i]);
          if (pre[m] + tk[m] < D) begin
            q[k][m].push_back(expWord(evtError[i], evtVc[i*15 +: 15], evtNextValid[i],
                                      evtDescLo[i*15 +: 15]));
            tk[m]++;
            stored[m] = 1'b1;
          end else drop[m] = 1'b1;
        end
      end
      ovfE[k] = (ovfE[k] & ~ovfClr) | drop;
      if (k == 1) stE[k] = (stE[k] & ~stClr) | stored;
      if (maskWe) maskE[k] = maskData;
    end
  endtask

  task automatic compareAll();
    for (int k = 0; k < 2; k++) begin
      logic av;
      logic [NM-1:0] st;
      av = (q[k][rdMbox].size() != 0);
      check("R2 avail", {31'b0, rdAvailW[k]}, {31'b0, av});
      if (av) check("R1 R2 data", rdDataW[k], q[k][rdMbox][0]);
      for (int m = 0; m < NM; m++) st[m] = (q[k][m].size() != 0);
      if (k == 0) check("R5 status", {30'b0, statusW[k]}, {30'b0, st});
      else        check("R6 status", {30'b0, statusW[k]}, {30'b0, stE[k]});
      check("R3 overflow", {30'b0, ovfW[k]}, {30'b0, ovfE[k]});
      check("R7 R8 irq", {31'b0, irqW[k]}, {31'b0, irqE[k]});
    end
  endtask

  task automatic tick();
    modelStep();
    @(posedge clk);
    @(negedge clk);
    compareAll();
  endtask

  initial begin
    int cycles = 0;
    while (cycles < 200000) begin
      @(posedge clk);
      cycles++;
    end
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [31:0] wC, wE, wF;
    void'($urandom(32'h5EED_0A11));
    clearIn();
    rdMbox = 1'b0;
    for (int k = 0; k < 2; k++) begin
      stE[k] = '0; ovfE[k] = '0; maskE[k] = '0; irqE[k] = 1'b0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 2; k++) begin  // R9 reset state
      check("R9 avail", {31'b0, rdAvailW[k]}, 32'd0);
      check("R9 status", {30'b0, statusW[k]}, 32'd0);
      check("R9 overflow", {30'b0, ovfW[k]}, 32'd0);
      check("R9 irq", {31'b0, irqW[k]}, 32'd0);
    end

    // R1 packing with error and idle flags
    clearIn(); setEvt(0, 1'b1, 15'h1234, 1'b0, 15'h6123, 1'b0); tick();
    check("R1 packed word", rdDataW[0], 32'h1234_6123);

    // R4 two events, one free slot
    clearIn(); setEvt(1, 1'b0, 15'h0011, 1'b1, 15'h0001, 1'b0); tick();
    clearIn(); setEvt(0, 1'b0, 15'h0022, 1'b1, 15'h0002, 1'b0); tick();
    wC = expWord(1'b0, 15'h7ABC, 1'b1, 15'h0333);
    clearIn();
    setEvt(0, 1'b0, 15'h7ABC, 1'b1, 15'h0333, 1'b0);
    setEvt(1, 1'b1, 15'h0444, 1'b0, 15'h0444, 1'b0);
    tick();
    check("R3 R4 overflow on drop", {31'b0, ovfW[0][0]}, 32'd1);
    clearIn(); rdPop = 1'b1; tick(); tick(); tick();
    clearIn(); check("R4 lower source kept", rdDataW[0], wC);
    rdPop = 1'b1; tick();
    clearIn(); check("R3 dropped entry absent", {31'b0, rdAvailW[0]}, 32'd0);

    // R4 two events into empty mailbox 1
    wE = expWord(1'b0, 15'h0E0E, 1'b0, 15'h0E01);
    wF = expWord(1'b1, 15'h0F0F, 1'b1, 15'h0F02);
    clearIn(); rdMbox = 1'b1;
    setEvt(0, 1'b0, 15'h0E0E, 1'b0, 15'h0E01, 1'b1);
    setEvt(1, 1'b1, 15'h0F0F, 1'b1, 15'h0F02, 1'b1);
    tick();
    clearIn(); check("R4 first of pair", rdDataW[0], wE);
    rdPop = 1'b1; tick();
    clearIn(); check("R4 second of pair", rdDataW[0], wF);
    rdPop = 1'b1; tick();

    // R8 masking
    clearIn(); rdMbox = 1'b0;
    setEvt(0, 1'b0, 15'h0055, 1'b1, 15'h0055, 1'b0);
    maskWe = 1'b1; maskData = 2'b11; tick();
    clearIn(); tick();
    check("R8 masked irq", {31'b0, irqW[0]}, 32'd0);
    maskWe = 1'b1; maskData = 2'b00; tick();
    clearIn(); tick();
    check("R7 unmasked irq", {31'b0, irqW[0]}, 32'd1);

    // R5 / R6 clear behaviour
    stClr = 2'b11; tick();
    clearIn();
    check("R5 clear ignored", {31'b0, statusW[0][0]}, 32'd1);
    check("R6 clear applied", {31'b0, statusW[1][0]}, 32'd0);
    ovfClr = 2'b11; tick();
    clearIn();
    check("R3 overflow cleared", {30'b0, ovfW[0]}, 32'd0);

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      clearIn();
      for (int i = 0; i < NS; i++) begin
        if (($urandom % 100) < 45)
          setEvt(i, 1'($urandom), 15'($urandom), 1'($urandom), 15'($urandom), 1'($urandom));
      end
      rdMbox = 1'($urandom);
      rdPop = (($urandom % 2) == 0);
      for (int m = 0; m < NM; m++) begin
        stClr[m] = (($urandom % 8) == 0);
        ovfClr[m] = (($urandom % 16) == 0);
      end
      maskWe = (($urandom % 16) == 0);
      maskData = 2'($urandom);
      tick();
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule